// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus. It keeps a small byte-wide data store in registers and serves it over the bus. The serial clock and the open-drain data line reach it as plain inputs. Each input passes through a two-flop synchronizer, and bus events are found on the synchronized copies. The block never drives the data line high. It only asserts a pull-low enable, and outside logic turns that enable into an open-drain driver.

A master begins every command with a START and sends a control byte. The upper nibble of that byte selects this device and its lowest bit chooses the direction. A write goes on with a word address and then any number of data bytes. A read returns bytes from an internal pointer, beginning with the most significant bit, until the master withholds its acknowledge. A random read is a write that carries only an address, followed by a repeated START and a read. After a write ends with STOP, the block runs a programming interval of fixed length. During that interval it refuses to answer its device code.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the pull-low enable is off, the busy flag is low and every one of the 16 bytes in the store reads back as 0x00.
- R2: A falling data line while the clock is high is a START. A START aborts any transfer in progress, from any state, and reception of a new control byte begins.
- R3: A control byte whose bits 7..4 are 1010 is acknowledged, and its bit 0 selects read (1) or write (0). Any other upper nibble gets no acknowledge. The slave then ignores the bus until the next START and leaves the pointer unchanged.
- R4: After each byte it accepts, the slave pulls the data line low for the whole ninth clock pulse and releases it after that pulse's falling edge.
- R5: The pull-low enable changes only while the serial clock is low.
- R6: While the busy flag is high, a control byte is not acknowledged and the pull-low enable stays off.
- R7: In a write, bits 3..0 of the address byte load the pointer. Each data byte that follows is acknowledged and later stored at the pointer. The pointer then increments and wraps from 15 to 0.
- R8: The last data byte of a write is stored only when the write ends in a STOP. If a START comes first, that byte is dropped and no programming interval starts.
- R9: A STOP that ends a write with at least one data byte raises the busy flag for exactly PROG_CYCLES clock cycles. A STOP after a frame that wrote no data byte leaves the flag as it was.
- R10: A read shifts out the byte at the pointer, MSB first, one bit per clock pulse. After each byte the pointer increments and wraps from 15 to 0. A master acknowledge moves on to the next byte.
- R11: A read with no address phase (a current-address read) returns the byte at the pointer left by the previous operation.
- R12: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus (asynchronous) |
| sda_i | input | 1 | Sensed level of the data line (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| busy_o | output | 1 | High during the internal programming interval |

## Verification
The bench targets the point where pointer wrap and sequential continuation meet: it writes across address 15 and reads back across it. A design without wrap would return bytes from the wrong cells. It aborts a write with a repeated START, which catches a design that commits the byte it still holds or starts a programming interval anyway. It sends a control byte while busy and another with a wrong device code. A design that acknowledges the first, or lets the ignored bytes move the pointer, shows up in the next current-address read. It also clocks a full byte after a master no-acknowledge to show the line stays released, and it measures the length of the busy interval.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = 4;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR,
        S_WDATA,
        S_RDATA
    } state_e;

    // Bus events derived from the synchronized line levels.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] ctrl);
        return ctrl[BYTE_W-1 -: 4] == DEV_CODE;
    endfunction

    function automatic logic is_rx_state(input state_e s);
        return (s == S_CTRL) || (s == S_ADDR) || (s == S_WDATA);
    endfunction

endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ee2w_bus_mon.sv
module ee2w_bus_mon
    import ee2w_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s && scl_p && sda_p && !sda_s;
        ev.stop  = scl_s && scl_p && !sda_p && sda_s;
        ev.rise  = scl_s && !scl_p;
        ev.fall  = !scl_s && scl_p;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/ee2w_store.sv
module ee2w_store
    import ee2w_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [BYTE_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && (waddr == AW'(g))) begin
                r <= wdata;
            end
        end
        assign cell_q[g] = r;
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/ee2w_prog_timer.sv
module ee2w_prog_timer #(
    parameter int CYCLES = 200,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (go) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic busy_o
);

    // Input conditioning and event detection
    logic [1:0] line_s;
    logic       scl_s;
    logic       sda_s;
    bus_ev_t    ev;

    ee2w_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    ee2w_bus_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (ev)
    );

    // Protocol state
    state_e              state;
    logic [BIT_CW-1:0]   bitcnt;
    logic                ack_ph;
    logic                ack_ok;
    logic                rw;
    logic                m_ack;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   tx;
    logic [AW-1:0]       ptr;
    logic                pull_q;

    // One-byte write holding register
    logic                pend_valid;
    logic [AW-1:0]       pend_addr;
    logic [BYTE_W-1:0]   pend_data;

    logic                busy;
    logic [BYTE_W-1:0]   rd_data;
    logic                ack_ok_c;
    logic                byte_dec;
    logic                wr_commit;
    logic                prog_go;
    logic                stop_ev;
    logic                st_idle;

    always_comb begin
        ack_ok_c = 1'b1;
        if (state == S_CTRL) begin
            ack_ok_c = dev_match(shreg) && !busy;
        end
    end

    assign byte_dec  = ev.fall && !ack_ph && (bitcnt == BIT_CW'(8)) && is_rx_state(state);
    assign prog_go   = ev.stop && pend_valid;
    assign wr_commit = prog_go || (byte_dec && (state == S_WDATA) && pend_valid);
    assign stop_ev   = ev.stop;
    assign st_idle   = (state == S_IDLE);

    ee2w_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_commit),
        .waddr (pend_addr),
        .wdata (pend_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

    ee2w_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (prog_go),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            bitcnt     <= '0;
            ack_ph     <= 1'b0;
            ack_ok     <= 1'b0;
            rw         <= 1'b0;
            m_ack      <= 1'b0;
            shreg      <= '0;
            tx         <= '0;
            ptr        <= '0;
            pull_q     <= 1'b0;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (ev.start) begin
            state      <= S_CTRL;
            bitcnt     <= '0;
            ack_ph     <= 1'b0;
            pull_q     <= 1'b0;
            pend_valid <= 1'b0;
        end else if (ev.stop) begin
            state      <= S_IDLE;
            ack_ph     <= 1'b0;
            pull_q     <= 1'b0;
            pend_valid <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                end
                S_CTRL, S_ADDR, S_WDATA: begin
                    if (ev.rise && !ack_ph && (bitcnt < BIT_CW'(8))) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_dec) begin
                        ack_ph <= 1'b1;
                        ack_ok <= ack_ok_c;
                        pull_q <= ack_ok_c;
                        if (state == S_CTRL) begin
                            rw <= shreg[0];
                        end else if (state == S_ADDR) begin
                            ptr <= shreg[AW-1:0];
                        end else begin
                            pend_valid <= 1'b1;
                            pend_addr  <= ptr;
                            pend_data  <= shreg;
                            ptr        <= ptr + 1'b1;
                        end
                    end else if (ev.fall && ack_ph) begin
                        ack_ph <= 1'b0;
                        bitcnt <= '0;
                        pull_q <= 1'b0;
                        if (!ack_ok) begin
                            state <= S_IDLE;
                        end else if (state == S_CTRL) begin
                            if (rw) begin
                                state  <= S_RDATA;
                                tx     <= rd_data;
                                pull_q <= !rd_data[BYTE_W-1];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                state <= S_ADDR;
                            end
                        end else begin
                            state <= S_WDATA;
                        end
                    end
                end
                S_RDATA: begin
                    if (ev.rise && (bitcnt == BIT_CW'(8))) begin
                        m_ack <= !ev.sda;
                    end else if (ev.fall) begin
                        if (bitcnt < BIT_CW'(7)) begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            pull_q <= !tx[BYTE_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end else if (bitcnt == BIT_CW'(7)) begin
                            pull_q <= 1'b0;
                            bitcnt <= BIT_CW'(8);
                        end else if (m_ack) begin
                            tx     <= rd_data;
                            pull_q <= !rd_data[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                        end else begin
                            pull_q <= 1'b0;
                            state  <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign sda_pull_o = pull_q;
    assign busy_o     = busy;

endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk #(
    parameter int PROG_CYCLES = 200
) (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic stop_ev,
    input logic st_idle,
    input logic sda_pull_o,
    input logic busy_o
);

    int busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= 0;
        end else if (busy_o) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R5
    a_r5_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

    // R6
    a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !sda_pull_o);

    // R12
    a_r12_idle_released: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> !sda_pull_o);

    // R9
    a_r9_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_ev));

    a_r9_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_run < PROG_CYCLES));

    a_r9_busy_exact: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_run == PROG_CYCLES));

endmodule

bind ee2w_slave ee2w_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .stop_ev    (stop_ev),
    .st_idle    (st_idle),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o)
);

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;

    localparam int PROG = 1000;
    localparam int Q = 10;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pull;
    logic busy;
    wire  sda_bus = m_sda & ~pull;

    always #5 clk = ~clk;

    ee2w_slave #(.PROG_CYCLES(PROG)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (pull),
        .busy_o     (busy)
    );

    int n_chk = 0;
    int n_err = 0;
    int busy_total = 0;
    int r5_bad = 0;
    logic prev_pull = 1'b0;

    always @(negedge clk) begin
        if (busy) busy_total++;
        if (!rst && (pull != prev_pull) && m_scl) r5_bad++;
        prev_pull = pull;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b0; step(H);
        m_scl = 1'b0; step(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; step(H);
        bus_start();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; step(Q);
        m_scl = 1'b1; step(H);
        m_sda = 1'b1; step(H);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; step(Q);
        m_scl = 1'b1; step(H);
        m_scl = 1'b0; step(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; step(H/2);
        b = sda_bus; step(H/2);
        m_scl = 1'b0; step(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!give_ack);
    endtask

    task automatic wait_idle();
        while (busy) step(1);
        step(2);
    endtask

    task automatic t_reset();
        chk("R1", "pull after reset", pull, 0);
        chk("R1", "busy after reset", busy, 0);
    endtask

    task automatic t_write_pair();
        logic a;
        int b0;
        bus_start();
        send_byte(8'hA0, a); chk("R3", "write ctrl ack", a, 1);
        send_byte(8'h03, a); chk("R4", "addr ack", a, 1);
        send_byte(8'hA5, a); chk("R7", "data0 ack", a, 1);
        send_byte(8'h5A, a); chk("R7", "data1 ack", a, 1);
        b0 = busy_total;
        bus_stop();
        chk("R9", "busy after stop", busy, 1);
        wait_idle();
        chk("R9", "busy length", busy_total - b0, PROG);
    endtask

    task automatic t_seq_write_busy();
        logic a;
        int b0;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h0E, a);
        send_byte(8'h11, a); chk("R7", "seq data 14 ack", a, 1);
        send_byte(8'h22, a); chk("R7", "seq data 15 ack", a, 1);
        send_byte(8'h33, a); chk("R7", "seq data wrap ack", a, 1);
        b0 = busy_total;
        bus_stop();
        bus_start();
        send_byte(8'hA0, a); chk("R6", "ctrl ack while busy", a, 0);
        bus_stop();
        chk("R6", "still busy", busy, 1);
        wait_idle();
        chk("R9", "busy not restarted by empty stop", busy_total - b0, PROG);
    endtask

    task automatic t_rand_read_wrap();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h0E, a);
        bus_rstart();
        send_byte(8'hA1, a); chk("R10", "read ctrl ack", a, 1);
        recv_byte(v, 1'b1); chk("R10", "byte at 14", v, 8'h11);
        recv_byte(v, 1'b1); chk("R10", "byte at 15", v, 8'h22);
        recv_byte(v, 1'b0); chk("R7", "byte wrapped to 0", v, 8'h33);
        chk("R12", "released after master nack", pull, 0);
        recv_byte(v, 1'b0); chk("R12", "silent after nack", v, 8'hFF);
        bus_stop();
    endtask

    task automatic t_reset_value();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h02, a);
        bus_rstart();
        send_byte(8'hA1, a);
        recv_byte(v, 1'b0); chk("R1", "untouched cell reads zero", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_current_and_bad_code();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA1, a); chk("R11", "current read ack", a, 1);
        recv_byte(v, 1'b0); chk("R11", "current read at 3", v, 8'hA5);
        bus_stop();
        bus_start();
        send_byte(8'h91, a); chk("R3", "foreign code nack", a, 0);
        send_byte(8'h07, a); chk("R3", "byte after foreign code ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hAF, a); chk("R2", "new start accepted (don't-care bits set)", a, 1);
        recv_byte(v, 1'b0); chk("R3", "pointer kept through foreign frame", v, 8'h5A);
        bus_stop();
    endtask

    task automatic t_abort_write();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h07, a);
        send_byte(8'h77, a); chk("R8", "aborted data ack", a, 1);
        bus_rstart();
        chk("R8", "no busy after abort", busy, 0);
        send_byte(8'hA0, a); chk("R2", "restart ctrl ack", a, 1);
        send_byte(8'h07, a);
        bus_rstart();
        send_byte(8'hA1, a);
        recv_byte(v, 1'b0); chk("R8", "aborted byte not stored", v, 8'h00);
        bus_stop();
        step(5);
        chk("R8", "busy stays low", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step(5);
        rst = 1'b0;
        step(5);
        t_reset();
        t_write_pair();
        t_seq_write_busy();
        t_rand_read_wrap();
        t_reset_value();
        t_current_and_bad_code();
        t_abort_write();
        chk("R5", "pull changes while scl high", r5_bad, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule